// File: doc/BRIEF.md
# DS3 Payload Parity Monitor

This block sits behind a DS3 receive framer that has already found frame alignment. It takes the received line one bit at a time, together with marks that say where an M-frame begins, which bits carry payload and which two positions carry the parity bits. For every M-frame it forms the even parity of the payload bits only. It then checks that value against the two parity bits carried in the frame that follows.

Every mismatch is one parity error event. An event sets a sticky interrupt status bit and forces the far-end block error code for the return direction away from all ones. It also adds one to a saturating event counter. A processor reads the counter through a byte-wide read port, and the read also clears it. When parity-based framing is enabled, errors in two of any five consecutive checked M-frames declare out-of-frame. Checking is then frozen until the alignment logic signals that framing has been recovered.

Top module: `ds3_parity_mon`

## Requirements
- R1: Only bits with `bit_vld` high and `pay_q` high enter the parity of a frame. Overhead bits and cycles with `bit_vld` low do not affect the outcome.
- R2: At each valid `mf_start`, the parity bits captured in the frame that just ended are compared with the even parity of the frame before it. The outputs change on that clock edge.
- R3: If the two parity bits of one frame differ from each other, the frame counts as one parity error.
- R4: Register address 0 returns the interrupt status in bit 0, with the other bits zero. An error sets the bit. A read of address 0 clears it, unless an error occurs in the same cycle.
- R5: `febe_code` is 3'b111 after reset and after a clean check. It is 3'b000 after a check that found an error, and it holds that value until the next check.
- R6: The error count is 0 after reset and rises by one per error. Address 1 returns its high byte and address 2 returns the low byte latched at the last read of address 1.
- R7: A read of address 1 latches the low byte and clears the count in the same cycle. An error in that cycle leaves the count at 1.
- R8: The count saturates at its all-ones value instead of wrapping.
- R9: With `oof_en` high, `oof` rises on the check that brings the number of errors among the last five checks to two. With `oof_en` low, `oof` never rises.
- R10: No check is made at the first frame boundary after reset or after `realign_done`. The parity bits of the first frame are never compared.
- R11: While `oof` is high, no checking or counting takes place. A `realign_done` pulse clears `oof`, clears the five-frame history and returns `febe_code` to 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | A received bit is present this cycle |
| bit_in | input | 1 | Received data bit |
| mf_start | input | 1 | This bit is the first bit of an M-frame |
| pay_q | input | 1 | This bit belongs to the payload |
| p1_q | input | 1 | This bit is the first parity bit position |
| p2_q | input | 1 | This bit is the second parity bit position |
| oof_en | input | 1 | Enable out-of-frame declaration from parity errors |
| realign_done | input | 1 | Framing recovered: clear out-of-frame and restart checking |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Register select: 0 status, 1 count high, 2 count low |
| rd_data | output | 8 | Read data for the selected register |
| perr_irq | output | 1 | Parity error interrupt status |
| febe_code | output | 3 | Far-end block error code for the return direction |
| oof | output | 1 | Out-of-frame declared from parity errors |

## Verification
The bench builds two copies that share all stimulus. One uses the default 16-bit counter and the other uses a 4-bit counter. The narrow copy reaches its saturation limit after fifteen errors, so the no-wrap rule is checked within a short run, while the wide copy counts the same events exactly. The five-frame window and the two-error threshold stay at their defaults. This allows errors spaced five checks apart to be shown to stay below the threshold, while errors spaced three apart trip it.

// File: rtl/ds3_parity_mon.sv
`timescale 1ns/1ps
module ds3_parity_mon #(
  parameter int CNT_W    = 16,
  parameter int WIN      = 5,
  parameter int OOF_HITS = 2
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_vld,
  input  logic       bit_in,
  input  logic       mf_start,
  input  logic       pay_q,
  input  logic       p1_q,
  input  logic       p2_q,
  input  logic       oof_en,
  input  logic       realign_done,
  input  logic       rd_en,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       perr_irq,
  output logic [2:0] febe_code,
  output logic       oof
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             started, ref_ok, ref_par, acc;
  logic             p1_v, p2_v, p1_s, p2_s;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       snap;
  logic [WIN-2:0]   win;
  logic             irq_r, oof_r;
  logic [2:0]       febe_r;

  wire tick    = bit_vld & ~oof_r;
  wire bnd     = tick & mf_start;
  wire chk     = bnd & started & ref_ok & p1_v & p2_v;
  wire ev_err  = chk & ((p1_s ^ p2_s) | (p1_s ^ ref_par));
  wire pay_bit = pay_q & bit_in;
  wire rd_st   = rd_en & (rd_addr == 2'd0);
  wire rd_hi   = rd_en & (rd_addr == 2'd1);
  wire [WIN-1:0] win_nx = {win, ev_err};
  wire [15:0]    cnt16  = 16'(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      ref_ok  <= 1'b0;
      ref_par <= 1'b0;
      acc     <= 1'b0;
      p1_v    <= 1'b0;
      p2_v    <= 1'b0;
      p1_s    <= 1'b0;
      p2_s    <= 1'b0;
    end else if (realign_done) begin
      started <= 1'b0;
      ref_ok  <= 1'b0;
    end else if (tick) begin
      if (mf_start) begin
        started <= 1'b1;
        acc     <= pay_bit;
        if (started) begin
          ref_par <= acc;
          ref_ok  <= 1'b1;
        end
      end else begin
        acc <= acc ^ pay_bit;
      end
      if (mf_start || p1_q) begin
        p1_v <= p1_q;
        p1_s <= bit_in;
      end
      if (mf_start || p2_q) begin
        p2_v <= p2_q;
        p2_s <= bit_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oof_r  <= 1'b0;
      win    <= '0;
      febe_r <= 3'b111;
    end else if (realign_done) begin
      oof_r  <= 1'b0;
      win    <= '0;
      febe_r <= 3'b111;
    end else if (chk) begin
      win    <= win_nx[WIN-2:0];
      febe_r <= ev_err ? 3'b000 : 3'b111;
      if (oof_en && ($countones(win_nx) >= OOF_HITS))
        oof_r <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      snap <= '0;
    end else if (rd_hi) begin
      snap <= cnt16[7:0];
      cnt  <= ev_err ? CNT_W'(1) : '0;
    end else if (ev_err && cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_r <= 1'b0;
    else if (rd_st)  irq_r <= ev_err;
    else if (ev_err) irq_r <= 1'b1;
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {7'b0, irq_r};
      2'd1:    rd_data = cnt16[15:8];
      2'd2:    rd_data = snap;
      default: rd_data = 8'h00;
    endcase
  end

  assign perr_irq  = irq_r;
  assign febe_code = febe_r;
  assign oof       = oof_r;
endmodule

// File: rtl/ds3_parity_mon_chk.sv
`timescale 1ns/1ps
module ds3_parity_mon_chk #(
  parameter int CNT_W = 16
)(
  input logic             clk,
  input logic             rst_n,
  input logic             oof_en,
  input logic             realign_done,
  input logic             rd_en,
  input logic [1:0]       rd_addr,
  input logic             perr_irq,
  input logic [2:0]       febe_code,
  input logic             oof,
  input logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ALL1 = '1;
  wire rdh = rd_en && (rd_addr == 2'd1);

  assert_febe_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (febe_code == 3'b111) || (febe_code == 3'b000));

  assert_oof_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oof) |-> $past(oof_en));

  assert_oof_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(oof) && !$past(realign_done)) |-> oof);

  assert_realign_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(realign_done) |-> !oof);

  assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rdh) |-> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1)));

  assert_cnt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rdh) |-> (cnt <= CNT_W'(1)));

  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt) == ALL1 && !$past(rdh)) |-> (cnt == ALL1));

  assert_irq_on_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rdh) && $past(cnt) != ALL1 && cnt == CNT_W'($past(cnt) + 1'b1)) |-> perr_irq);
endmodule

bind ds3_parity_mon ds3_parity_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .oof_en(oof_en), .realign_done(realign_done),
  .rd_en(rd_en), .rd_addr(rd_addr), .perr_irq(perr_irq),
  .febe_code(febe_code), .oof(oof), .cnt(cnt)
);

// File: tb/tb_ds3_parity_mon.sv
`timescale 1ns/1ps
module tb_ds3_parity_mon;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, bit_vld, bit_in, mf_start, pay_q, p1_q, p2_q, oof_en, realign_done, rd_en;
  logic [1:0] rd_addr;
  logic [7:0] rd_data, rd_data_s;
  logic perr_irq, s_irq, oof, s_oof;
  logic [2:0] febe_code, s_febe;

  int ntot = 0, nfail = 0, nfr = 0, prev_mode = 0;
  logic prev_par = 1'b0;
  logic [2:0] b_febe;
  logic b_oof;
  logic [7:0] hi_seen, d, ds;

  // entry: {gap, payload[12:0], mode}; mode 0 correct, 1 both P-bits flipped, 2 second P-bit flipped
  localparam logic [15:0] VEC [12] = '{
    {1'b0, 13'h0A5, 2'd1}, {1'b0, 13'h1F3, 2'd0}, {1'b1, 13'h002, 2'd0},
    {1'b0, 13'h111, 2'd0}, {1'b0, 13'h0FF, 2'd1}, {1'b1, 13'h1AB, 2'd0},
    {1'b0, 13'h047, 2'd2}, {1'b0, 13'h1C0, 2'd0}, {1'b1, 13'h0E1, 2'd0},
    {1'b0, 13'h000, 2'd0}, {1'b0, 13'h1FF, 2'd0}, {1'b0, 13'h09C, 2'd0}
  };
  localparam int OMODE [15] = '{1, 0, 1, 0, 0, 0, 0, 1, 0, 0, 2, 0, 1, 1, 1};

  ds3_parity_mon dut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in), .mf_start(mf_start),
    .pay_q(pay_q), .p1_q(p1_q), .p2_q(p2_q), .oof_en(oof_en), .realign_done(realign_done),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .perr_irq(perr_irq),
    .febe_code(febe_code), .oof(oof));

  ds3_parity_mon #(.CNT_W(4)) dut_sat (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in), .mf_start(mf_start),
    .pay_q(pay_q), .p1_q(p1_q), .p2_q(p2_q), .oof_en(oof_en), .realign_done(realign_done),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data_s), .perr_irq(s_irq),
    .febe_code(s_febe), .oof(s_oof));

  task automatic check(input string req, input int act, input int exp);
    ntot++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] dv, output logic [7:0] dsv);
    rd_en = 1'b1; rd_addr = a;
    #1 dv = rd_data; dsv = rd_data_s;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic send_frame(input logic gap, input logic [12:0] pl, input int mode, input logic rdhi);
    logic p;
    int pi;
    p = prev_par; pi = 0;
    for (int pos = 0; pos < 16; pos++) begin
      if (gap && pos == 6) begin
        bit_vld = 1'b0; bit_in = 1'b1; mf_start = 1'b1; pay_q = 1'b1; p1_q = 1'b1; p2_q = 1'b0;
        @(posedge clk); #1;
      end
      bit_vld = 1'b1; mf_start = (pos == 0); p1_q = (pos == 3); p2_q = (pos == 9);
      pay_q = !(pos == 0 || pos == 3 || pos == 9);
      if (pos == 3)      bit_in = (mode == 1) ? ~p : p;
      else if (pos == 9) bit_in = (mode == 0) ? p : ~p;
      else if (pos == 0) bit_in = 1'b1;
      else begin bit_in = pl[pi]; pi++; end
      if (pos == 0 && rdhi) begin
        rd_en = 1'b1; rd_addr = 2'd1;
        #1 hi_seen = rd_data;
      end
      @(posedge clk); #1;
      rd_en = 1'b0;
      if (pos == 0) begin b_febe = febe_code; b_oof = oof; end
    end
    bit_vld = 1'b0; mf_start = 1'b0; pay_q = 1'b0; p1_q = 1'b0; p2_q = 1'b0; bit_in = 1'b0;
    prev_par = ^pl;
  endtask

  task automatic frame_chk(input logic [15:0] v, input logic do_f, input int exp_oof, input string req);
    int expf;
    expf = (nfr >= 2 && prev_mode != 0) ? 0 : 7;
    send_frame(v[15], v[14:2], int'(v[1:0]), 1'b0);
    if (do_f) check(req, int'(b_febe), expf);
    if (exp_oof >= 0) check(req, int'(b_oof), exp_oof);
    nfr++;
    prev_mode = int'(v[1:0]);
  endtask

  task automatic realign();
    realign_done = 1'b1;
    @(posedge clk); #1;
    realign_done = 1'b0;
    nfr = 0;
  endtask

  initial begin
    #200000;
    ntot++; nfail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_vld = 1'b0; bit_in = 1'b0; mf_start = 1'b0; pay_q = 1'b0;
    p1_q = 1'b0; p2_q = 1'b0; oof_en = 1'b0; realign_done = 1'b0; rd_en = 1'b0; rd_addr = 2'd0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    check("R5 reset febe", int'(febe_code), 7);
    check("R9 reset oof", int'(oof), 0);
    rd(2'd0, d, ds); check("R4 reset status", int'(d), 0);
    rd(2'd1, d, ds); check("R6 reset count high", int'(d), 0);
    rd(2'd2, d, ds); check("R6 reset count low", int'(d), 0);

    // R1 R2 R3 R5 R10: table of frames, junk overhead and gap cycles, disable OOF (R9)
    for (int i = 0; i < 12; i++) frame_chk(VEC[i], 1'b1, 0, "R1 R2 R3 R5 R9 R10 table");
    frame_chk(16'h0000, 1'b1, 0, "R2 R5 tail");

    rd(2'd0, d, ds); check("R4 status set", int'(d), 1);
    rd(2'd0, d, ds); check("R4 status cleared by read", int'(d), 0);
    rd(2'd1, d, ds); check("R6 count high", int'(d), 0);
    rd(2'd2, d, ds); check("R6 count low", int'(d), 2);
    rd(2'd1, d, ds); check("R7 cleared high", int'(d), 0);
    rd(2'd2, d, ds); check("R7 cleared low", int'(d), 0);

    // R7: error in the same cycle as the high-byte read
    frame_chk({1'b0, 13'h0F3, 2'd1}, 1'b1, 0, "R2 R5");
    send_frame(1'b0, 13'h055, 0, 1'b1);
    nfr++; prev_mode = 0;
    check("R7 high byte at collision", int'(hi_seen), 0);
    check("R5 febe on error", int'(b_febe), 0);
    rd(2'd1, d, ds); check("R7 collision high", int'(d), 0);
    rd(2'd2, d, ds); check("R7 collision counted as one", int'(d), 1);

    // R8: twenty errors, narrow copy saturates
    for (int k = 0; k < 20; k++) frame_chk({1'b0, 13'(k * 37), 2'd1}, 1'b1, 0, "R5 R8 run");
    frame_chk(16'h0000, 1'b1, 0, "R5 R8 tail");
    rd(2'd1, d, ds);
    check("R6 wide high", int'(d), 0);
    check("R8 narrow high", int'(ds), 0);
    rd(2'd2, d, ds);
    check("R6 wide count 20", int'(d), 20);
    check("R8 narrow saturated", int'(ds), 15);

    // R9 R10 R11: parity-based out-of-frame
    realign();
    oof_en = 1'b1;
    for (int k = 0; k < 12; k++)
      frame_chk({1'b0, 13'(k * 91 + 5), 2'(OMODE[k])}, 1'b1, (k == 11) ? 1 : 0, "R9 R10 window");
    for (int k = 12; k < 15; k++)
      frame_chk({1'b0, 13'(k * 91 + 5), 2'(OMODE[k])}, 1'b0, 1, "R11 held");
    rd(2'd1, d, ds); check("R11 count high", int'(d), 0);
    rd(2'd2, d, ds); check("R11 no counting while oof", int'(d), 3);
    realign();
    check("R11 oof cleared", int'(oof), 0);
    check("R11 febe restored", int'(febe_code), 7);
    frame_chk({1'b0, 13'h123, 2'd1}, 1'b1, 0, "R10 first after realign");
    frame_chk({1'b0, 13'h0AA, 2'd0}, 1'b1, 0, "R10 second after realign");
    frame_chk({1'b0, 13'h0AA, 2'd0}, 1'b1, 0, "R10 first frame P-bits ignored");
    rd(2'd1, d, ds);
    rd(2'd2, d, ds); check("R10 nothing counted", int'(d), 0);

    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end
endmodule